// File: doc/BRIEF.md
# SD/MMC Command Line Sequencer

This block drives one SD/MMC command onto the bidirectional CMD wire and can then capture the card's reply. Software loads a command word and a 32-bit argument, then pulses a start strobe. The engine sends an optional 80-clock preamble with CMD held high, and then the 48-bit command frame, which ends with a CRC7. If a response is expected, it releases the wire for a fixed turnaround and then waits a programmable number of card clocks for a start bit. It parses either a 48-bit short reply or a 136-bit long reply and checks it. Before it returns to idle, it waits a fixed recovery gap. Every step advances only on a card-clock enable pulse, so the block runs from the system clock at any card rate.

The sixteen-state sequencer exposes its state as a 4-bit code. Four 32-bit response words, the index of the last reply, and four result flags give software the outcome. The CMD pad is modelled as a separate output, output enable and input.

Top module: `sdcmd_engine`

## Requirements
- R1: After a synchronous active-low reset, the following hold: `fsm_code` is 0, `cmd_oe` is 0, `cmd_o` is 1, `cmd_busy`, `cmd_done`, the three error flags, all response words and `rsp_last_idx` are 0.
- R2: A command frame is sent MSB first as a 0 start bit, a 1 direction bit, the index from `cmd_word[5:0]`, the 32-bit argument, a CRC7 and a 1 end bit. The CRC7 uses generator x^7+x^3+1 with a zero seed, computed over the first 40 frame bits. `cmd_oe` is high exactly while preamble or frame bits are driven.
- R3: When `cmd_word[15]` is set, CMD is driven high for 80 card clocks in state code 1 before the start bit.
- R4: State codes are 0 idle, 1 preamble, 2 start, 3 direction, 4 index+argument, 5 CRC, 6 end, 7 await start bit, 8 interrupt reply (reserved, never entered), 9 reply direction, 10 reply index, 11 reply payload, 12 reply CRC, 13 reply end, 14 recovery wait, 15 turnaround. A command visits them in that frame order, with 15 coming after 6 when `cmd_word[6]` asks for a reply and 14 coming last.
- R5: A strobe on `cmd_start` is taken only when `cmd_word[31]` is 1 and `cmd_busy` is 0. `cmd_busy` stays 1 until the command finishes and then self-clears. Strobes taken while busy do not alter the command in flight.
- R6: Without a reply, the end bit is followed by 8 card clocks in state 14, then `cmd_done`, with all error flags 0.
- R7: With a timeout value T ≥ 1 and the 2-clock turnaround (state 15), the start bit is accepted only on one of the first T card clocks spent in state 7. Otherwise `err_tmo` is set, and the command goes through the 8-clock recovery wait and then finishes.
- R8: A short reply (`cmd_word[7]`=0) is 48 bits. Its 32 payload bits go to `rsp_w0`, while `rsp_w1` to `rsp_w3` keep their values. `rsp_last_idx` takes the received 6-bit index.
- R9: A long reply (`cmd_word[7]`=1) is 136 bits. `{rsp_w3,rsp_w2,rsp_w1,rsp_w0}` takes the 120 payload bits, then the received CRC7, then the end bit. The index field is not compared, and the CRC covers only the payload.
- R10: With `cmd_word[8]` set, a mismatch between the received CRC7 and the computed one sets `err_crc`. With `cmd_word[8]` clear, a mismatch raises no flag.
- R11: A 0 end bit, or a short-reply index that differs from the sent index, sets `err_resp`.
- R12: The sequencer changes state only on clock edges where `card_ce` is 1, and each frame bit is held until such an edge.
- R13: `cmd_done` is a one-cycle pulse. The error flags hold their values until the next accepted strobe clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| card_ce | input | 1 | Card-clock enable pulse |
| cmd_word | input | 32 | Command word (index, reply flags, preamble, start) |
| cmd_arg | input | 32 | Command argument |
| cmd_start | input | 1 | Start strobe |
| rsp_tmo | input | 8 | Reply timeout in card clocks |
| cmd_i | input | 1 | CMD pad input |
| cmd_o | output | 1 | CMD pad output value |
| cmd_oe | output | 1 | CMD pad output enable |
| rsp_w0 | output | 32 | Response word 0 |
| rsp_w1 | output | 32 | Response word 1 |
| rsp_w2 | output | 32 | Response word 2 |
| rsp_w3 | output | 32 | Response word 3 |
| rsp_last_idx | output | 6 | Index of last reply |
| fsm_code | output | 4 | Current state code |
| cmd_busy | output | 1 | Start bit readback, self-clearing |
| cmd_done | output | 1 | Completion pulse |
| err_resp | output | 1 | End-bit or index error |
| err_crc | output | 1 | Reply CRC mismatch |
| err_tmo | output | 1 | No start bit in time |

## Verification
The bench builds the engine with its default parameters: an 80-clock preamble, a 2-clock turnaround, an 8-clock recovery wait and an 8-bit timeout. With these values, exact preamble and wait lengths can be counted cycle by cycle. Because the timeout is a run-time input, small values of 2 and 3 make it possible to place a card start bit exactly on, and one clock past, the acceptance boundary. One command runs with the card enable at one clock in three to expose any step that is not gated.

// File: rtl/sdcmd_pkg.sv
// Shared definitions for the CMD-line sequencer: state codes and command
// word bit positions. Assumes a 32-bit command word.
package sdcmd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE     = 4'd0,
        ST_INIT     = 4'd1,
        ST_TX_START = 4'd2,
        ST_TX_DIR   = 4'd3,
        ST_TX_BODY  = 4'd4,
        ST_TX_CRC   = 4'd5,
        ST_TX_END   = 4'd6,
        ST_RX_START = 4'd7,
        ST_RX_IRQ   = 4'd8,
        ST_RX_DIR   = 4'd9,
        ST_RX_IDX   = 4'd10,
        ST_RX_BODY  = 4'd11,
        ST_RX_CRC   = 4'd12,
        ST_RX_END   = 4'd13,
        ST_NCC_WAIT = 4'd14,
        ST_TURN     = 4'd15
    } cmd_state_e;

    localparam int CW_IDX_LSB = 0;
    localparam int CW_IDX_W   = 6;
    localparam int CW_RESP    = 6;
    localparam int CW_LONG    = 7;
    localparam int CW_CHKCRC  = 8;
    localparam int CW_INIT    = 15;
    localparam int CW_GO      = 31;

endpackage

// File: rtl/sdcmd_crc7.sv
// Serial CRC register, MSB-first feed. Generator given by POLY without the
// top term (default x^7+x^3+1). Assumes clr has priority over en and
// shift_out, and that en and shift_out are never both high.
module sdcmd_crc7 #(
    parameter int             W    = 7,
    parameter logic [W-1:0]   POLY = 7'h09
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         shift_out,
    input  logic         din,
    output logic [W-1:0] crc
);
    logic         fb;
    logic [W-1:0] crc_q;

    assign fb  = din ^ crc_q[W-1];
    assign crc = crc_q;

    // Update remainder: clear, absorb one bit, or shift out toward the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            crc_q <= '0;
        end else if (en) begin
            crc_q <= {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end else if (shift_out) begin
            crc_q <= {crc_q[W-2:0], 1'b0};
        end
    end

    // R2
    crc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc_q == '0));
endmodule

// File: rtl/sdcmd_rx_shreg.sv
// Reply capture shift register, LSB entry. Holds the last W bits shifted
// in; contents are only meaningful once the whole reply has arrived.
module sdcmd_rx_shreg #(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] q
);
    logic [W-1:0] q_r;
    assign q = q_r;

    // Shift one received bit in per enabled card clock.
    always_ff @(posedge clk) begin
        if (!rst_n) q_r <= '0;
        else if (shift_en) q_r <= {q_r[W-2:0], din};
    end
endmodule

// File: rtl/sdcmd_engine.sv
// CMD-line sequencer: sends one command frame, optionally captures and
// checks a short or long reply, reports state and result. Assumes card_ce
// is a one-system-clock pulse per card clock and that cmd_i is already
// synchronised to clk.
module sdcmd_engine
    import sdcmd_pkg::*;
#(
    parameter int INIT_CLKS = 80,
    parameter int TURN_CLKS = 2,
    parameter int NCC_CLKS  = 8,
    parameter int TMO_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             card_ce,
    input  logic [31:0]      cmd_word,
    input  logic [31:0]      cmd_arg,
    input  logic             cmd_start,
    input  logic [TMO_W-1:0] rsp_tmo,
    input  logic             cmd_i,
    output logic             cmd_o,
    output logic             cmd_oe,
    output logic [31:0]      rsp_w0,
    output logic [31:0]      rsp_w1,
    output logic [31:0]      rsp_w2,
    output logic [31:0]      rsp_w3,
    output logic [5:0]       rsp_last_idx,
    output logic [3:0]       fsm_code,
    output logic             cmd_busy,
    output logic             cmd_done,
    output logic             err_resp,
    output logic             err_crc,
    output logic             err_tmo
);
    localparam int ARG_W     = 32;
    localparam int IDX_W     = CW_IDX_W;
    localparam int BODY_BITS = IDX_W + ARG_W;
    localparam int CRC_W     = 7;
    localparam int SHORT_PAY = 32;
    localparam int LONG_PAY  = 120;
    localparam int WORD_W    = 32;
    localparam int NWORDS    = 4;
    localparam int RSP_W     = WORD_W * NWORDS;
    localparam int CNT_MAX   = (INIT_CLKS > LONG_PAY) ? INIT_CLKS : LONG_PAY;
    localparam int CNT_W     = $clog2(CNT_MAX + 1);

    cmd_state_e           state_q;
    logic [CNT_W-1:0]     cnt_q;
    logic [TMO_W-1:0]     tmo_q, cfg_tmo;
    logic [BODY_BITS-1:0] txsh_q;
    logic [IDX_W-1:0]     cfg_idx, rxidx_q, last_idx_q;
    logic                 cfg_resp, cfg_long, cfg_chk, cfg_init;
    logic                 busy_q, done_q, e_resp_q, e_crc_q, e_tmo_q;
    logic                 accept, step, commit;
    logic [CRC_W-1:0]     tx_crc, rx_crc;
    logic [RSP_W-1:0]     rx_q, rx_full;
    logic [WORD_W-1:0]    rsp_q [NWORDS];
    logic                 tx_feed, rx_feed;

    assign accept  = cmd_start && cmd_word[CW_GO] && !busy_q;
    assign step    = card_ce;
    assign commit  = step && (state_q == ST_RX_END);
    assign rx_full = {rx_q[RSP_W-2:0], cmd_i};

    // Pad drive value and enable from the current state.
    always_comb begin
        cmd_o  = 1'b1;
        cmd_oe = 1'b1;
        case (state_q)
            ST_TX_START: cmd_o = 1'b0;
            ST_TX_BODY:  cmd_o = txsh_q[BODY_BITS-1];
            ST_TX_CRC:   cmd_o = tx_crc[CRC_W-1];
            ST_INIT, ST_TX_DIR, ST_TX_END: cmd_o = 1'b1;
            default:     cmd_oe = 1'b0;
        endcase
    end

    assign tx_feed = step && (state_q == ST_TX_START || state_q == ST_TX_DIR ||
                              state_q == ST_TX_BODY);
    assign rx_feed = step && ((state_q == ST_RX_BODY) ||
                     (!cfg_long && ((state_q == ST_RX_START && !cmd_i) ||
                                    state_q == ST_RX_DIR || state_q == ST_RX_IDX)));

    sdcmd_crc7 #(.W(CRC_W)) u_tx_crc (
        .clk(clk), .rst_n(rst_n), .clr(accept), .en(tx_feed),
        .shift_out(step && state_q == ST_TX_CRC), .din(cmd_o), .crc(tx_crc));

    sdcmd_crc7 #(.W(CRC_W)) u_rx_crc (
        .clk(clk), .rst_n(rst_n), .clr(state_q == ST_TURN), .en(rx_feed),
        .shift_out(1'b0), .din(cmd_i), .crc(rx_crc));

    sdcmd_rx_shreg #(.W(RSP_W)) u_rx_sh (
        .clk(clk), .rst_n(rst_n),
        .shift_en(step && (state_q == ST_RX_BODY || state_q == ST_RX_CRC)),
        .din(cmd_i), .q(rx_q));

    // Command sequencer: latch on strobe, advance one step per card clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            tmo_q    <= '0;
            txsh_q   <= '0;
            cfg_idx  <= '0;
            cfg_tmo  <= '0;
            {cfg_resp, cfg_long, cfg_chk, cfg_init} <= '0;
            {busy_q, done_q, e_resp_q, e_crc_q, e_tmo_q} <= '0;
            rxidx_q    <= '0;
            last_idx_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                cfg_idx  <= cmd_word[CW_IDX_LSB +: IDX_W];
                cfg_resp <= cmd_word[CW_RESP];
                cfg_long <= cmd_word[CW_LONG];
                cfg_chk  <= cmd_word[CW_CHKCRC];
                cfg_init <= cmd_word[CW_INIT];
                cfg_tmo  <= rsp_tmo;
                txsh_q   <= {cmd_word[CW_IDX_LSB +: IDX_W], cmd_arg};
                busy_q   <= 1'b1;
                {e_resp_q, e_crc_q, e_tmo_q} <= '0;
            end
            if (step) begin
                case (state_q)
                    ST_IDLE: if (busy_q) begin
                        state_q <= cfg_init ? ST_INIT : ST_TX_START;
                        cnt_q   <= CNT_W'(INIT_CLKS - 1);
                    end
                    ST_INIT: begin
                        if (cnt_q == '0) state_q <= ST_TX_START;
                        else cnt_q <= cnt_q - 1'b1;
                    end
                    ST_TX_START: state_q <= ST_TX_DIR;
                    ST_TX_DIR: begin
                        state_q <= ST_TX_BODY;
                        cnt_q   <= CNT_W'(BODY_BITS - 1);
                    end
                    ST_TX_BODY: begin
                        txsh_q <= {txsh_q[BODY_BITS-2:0], 1'b0};
                        if (cnt_q == '0) begin
                            state_q <= ST_TX_CRC;
                            cnt_q   <= CNT_W'(CRC_W - 1);
                        end else cnt_q <= cnt_q - 1'b1;
                    end
                    ST_TX_CRC: begin
                        if (cnt_q == '0) state_q <= ST_TX_END;
                        else cnt_q <= cnt_q - 1'b1;
                    end
                    ST_TX_END: begin
                        state_q <= cfg_resp ? ST_TURN : ST_NCC_WAIT;
                        cnt_q   <= cfg_resp ? CNT_W'(TURN_CLKS - 1) : CNT_W'(NCC_CLKS - 1);
                    end
                    ST_TURN: begin
                        if (cnt_q == '0) begin
                            state_q <= ST_RX_START;
                            tmo_q   <= cfg_tmo;
                        end else cnt_q <= cnt_q - 1'b1;
                    end
                    ST_RX_START: begin
                        if (!cmd_i) state_q <= ST_RX_DIR;
                        else if (tmo_q <= TMO_W'(1)) begin
                            e_tmo_q <= 1'b1;
                            state_q <= ST_NCC_WAIT;
                            cnt_q   <= CNT_W'(NCC_CLKS - 1);
                        end else tmo_q <= tmo_q - 1'b1;
                    end
                    ST_RX_DIR: begin
                        state_q <= ST_RX_IDX;
                        cnt_q   <= CNT_W'(IDX_W - 1);
                    end
                    ST_RX_IDX: begin
                        rxidx_q <= {rxidx_q[IDX_W-2:0], cmd_i};
                        if (cnt_q == '0) begin
                            state_q <= ST_RX_BODY;
                            cnt_q   <= cfg_long ? CNT_W'(LONG_PAY - 1) : CNT_W'(SHORT_PAY - 1);
                        end else cnt_q <= cnt_q - 1'b1;
                    end
                    ST_RX_BODY: begin
                        if (cnt_q == '0) begin
                            state_q <= ST_RX_CRC;
                            cnt_q   <= CNT_W'(CRC_W - 1);
                        end else cnt_q <= cnt_q - 1'b1;
                    end
                    ST_RX_CRC: begin
                        if (cnt_q == '0) state_q <= ST_RX_END;
                        else cnt_q <= cnt_q - 1'b1;
                    end
                    ST_RX_END: begin
                        e_resp_q   <= !cmd_i || (!cfg_long && rxidx_q != cfg_idx);
                        e_crc_q    <= cfg_chk && (rx_crc != rx_q[CRC_W-1:0]);
                        last_idx_q <= rxidx_q;
                        state_q    <= ST_NCC_WAIT;
                        cnt_q      <= CNT_W'(NCC_CLKS - 1);
                    end
                    ST_NCC_WAIT: begin
                        if (cnt_q == '0) begin
                            state_q <= ST_IDLE;
                            busy_q  <= 1'b0;
                            done_q  <= 1'b1;
                        end else cnt_q <= cnt_q - 1'b1;
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    // Response words: a long reply fills every word, a short one only word 0.
    for (genvar g = 0; g < NWORDS; g++) begin : g_rsp
        always_ff @(posedge clk) begin
            if (!rst_n) rsp_q[g] <= '0;
            else if (commit && cfg_long) rsp_q[g] <= rx_full[WORD_W*g +: WORD_W];
            else if (commit && g == 0) rsp_q[g] <= rx_full[CRC_W+1 +: SHORT_PAY];
        end
    end

    assign rsp_w0       = rsp_q[0];
    assign rsp_w1       = rsp_q[1];
    assign rsp_w2       = rsp_q[2];
    assign rsp_w3       = rsp_q[3];
    assign rsp_last_idx = last_idx_q;
    assign fsm_code     = state_q;
    assign cmd_busy     = busy_q;
    assign cmd_done     = done_q;
    assign err_resp     = e_resp_q;
    assign err_crc      = e_crc_q;
    assign err_tmo      = e_tmo_q;

    // R13
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done);
    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> (!cmd_busy && fsm_code == 4'd0));
    // R7
    tmo_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_tmo |-> (!err_resp && !err_crc));
    // R12
    ce_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !card_ce |=> $stable(state_q));
    // R4
    tx_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TX_START && $past(state_q) != ST_TX_START) |->
        ($past(state_q) == ST_IDLE || $past(state_q) == ST_INIT));
    // R2
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_oe) |-> (state_q == ST_TURN || state_q == ST_NCC_WAIT));
endmodule

// File: tb/sdcmd_engine_tb.sv
module sdcmd_engine_tb;
    typedef struct packed {
        logic [5:0]  idx;
        logic [31:0] arg;
        logic        rsp, lng, chk, ini, respond;
        logic [1:0]  bad;      // 0 clean, 1 flip CRC bit, 2 zero end bit
        logic [7:0]  tmo;
        logic [3:0]  gap;
        logic [5:0]  cidx;     // index the card returns (short reply)
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{6'd17, 32'hDEADBEEF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 8'd0,  4'd0, 6'd0},
        '{6'd0,  32'h00000000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd0,  4'd0, 6'd0},
        '{6'd8,  32'h000001AA, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 8'd20, 4'd4, 6'd8},
        '{6'd2,  32'h12345678, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2'd0, 8'd20, 4'd3, 6'd0},
        '{6'd13, 32'hCAFE0001, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'd1, 8'd20, 4'd4, 6'd13},
        '{6'd13, 32'hCAFE0002, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 8'd20, 4'd4, 6'd13},
        '{6'd55, 32'h0F0F0F0F, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 8'd20, 4'd5, 6'd54},
        '{6'd7,  32'h80000001, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'd2, 8'd20, 4'd4, 6'd7},
        '{6'd9,  32'hA5A55A5A, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2'd1, 8'd20, 4'd6, 6'd0},
        '{6'd3,  32'h00C0FFEE, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 8'd2,  4'd5, 6'd3},
        '{6'd3,  32'h11112222, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 8'd3,  4'd5, 6'd3},
        '{6'd41, 32'h33334444, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 8'd8,  4'd0, 6'd41}
    };

    logic        clk = 1'b0, rst_n = 1'b0, card_ce = 1'b1, cmd_start = 1'b0, cmd_i = 1'b1;
    logic [31:0] cmd_word = '0, cmd_arg = '0;
    logic [7:0]  rsp_tmo = '0;
    logic        cmd_o, cmd_oe, cmd_busy, cmd_done, err_resp, err_crc, err_tmo;
    logic [31:0] rsp_w0, rsp_w1, rsp_w2, rsp_w3;
    logic [5:0]  rsp_last_idx;
    logic [3:0]  fsm_code;

    int n_chk = 0, n_fail = 0;
    logic [127:0] exp_w = '0;
    logic [5:0]   exp_last = '0;

    always #5 clk = ~clk;

    sdcmd_engine u_dut (
        .clk(clk), .rst_n(rst_n), .card_ce(card_ce), .cmd_word(cmd_word),
        .cmd_arg(cmd_arg), .cmd_start(cmd_start), .rsp_tmo(rsp_tmo), .cmd_i(cmd_i),
        .cmd_o(cmd_o), .cmd_oe(cmd_oe), .rsp_w0(rsp_w0), .rsp_w1(rsp_w1),
        .rsp_w2(rsp_w2), .rsp_w3(rsp_w3), .rsp_last_idx(rsp_last_idx),
        .fsm_code(fsm_code), .cmd_busy(cmd_busy), .cmd_done(cmd_done),
        .err_resp(err_resp), .err_crc(err_crc), .err_tmo(err_tmo));

    task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] crc7(input logic [135:0] bits, input int n);
        logic [6:0] c = '0;
        for (int i = n - 1; i >= 0; i--) begin
            logic fb = bits[i] ^ c[6];
            c = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
        end
        return c;
    endfunction

    task automatic check_reset_state(input string tag);
        chk(fsm_code == 0 && !cmd_oe && cmd_o && !cmd_busy && !cmd_done,
            {tag, " R1 control"}, {fsm_code, cmd_oe, cmd_o, cmd_busy, cmd_done}, 8'h04);
        chk({err_resp, err_crc, err_tmo} == 3'b000, {tag, " R1 flags"},
            {err_resp, err_crc, err_tmo}, 0);
        chk({rsp_w3, rsp_w2, rsp_w1, rsp_w0, rsp_last_idx} == '0, {tag, " R1 response"},
            {rsp_w3, rsp_w2, rsp_w1, rsp_w0}, 0);
    endtask

    // Run one command; ce_div>1 slows the card clock, poke fires an extra strobe.
    task automatic run_cmd(input vec_t v, input int ce_div, input bit poke, input string tag);
        logic [31:0]  w = '0;
        logic [255:0] cap = '0, exp_tx = '0;
        int ncap = 0, nexp = 0;
        logic [135:0] frm = '0;
        int nb = 0, bi = 0, k = 0;
        logic [119:0] pay;
        logic [6:0]   c;
        int got_seq[32], exp_seq[32];
        int gn = 0, en = 0, n14 = 0, n15 = 0, last = 0, dones = 0;
        bit fall = 0, prev_oe = 0, seq_ok, timed, x_tmo, x_resp, x_crc;
        logic [63:0] gpk = '0, epk = '0;

        w[31] = 1'b1; w[15] = v.ini; w[8] = v.chk; w[7] = v.lng; w[6] = v.rsp; w[5:0] = v.idx;
        // expected command frame (R2, R3)
        if (v.ini) for (int i = 0; i < 80; i++) begin exp_tx = {exp_tx[254:0], 1'b1}; nexp++; end
        c = crc7({96'b0, 2'b01, v.idx, v.arg}, 40);
        exp_tx = {exp_tx[207:0], 2'b01, v.idx, v.arg, c, 1'b1}; nexp += 48;
        // card reply frame
        if (v.lng) begin
            pay = {v.arg, ~v.arg, v.arg ^ 32'h5A5A5A5A, v.arg[23:0]};
            c = crc7({16'b0, pay}, 120);
            if (v.bad == 2'd1) c = c ^ 7'd1;
            frm = {2'b00, 6'h3F, pay, c, (v.bad != 2'd2)}; nb = 136;
        end else begin
            pay = {88'b0, v.arg ^ 32'h0BADF00D};
            c = crc7({96'b0, 2'b00, v.cidx, pay[31:0]}, 40);
            if (v.bad == 2'd1) c = c ^ 7'd1;
            frm = {88'b0, 2'b00, v.cidx, pay[31:0], c, (v.bad != 2'd2)}; nb = 48;
        end
        timed  = v.rsp && (!v.respond || int'(v.gap) > 2 + int'(v.tmo));
        x_tmo  = timed;
        x_resp = v.rsp && !timed && ((v.bad == 2'd2) || (!v.lng && v.cidx != v.idx));
        x_crc  = v.rsp && !timed && v.chk && (v.bad == 2'd1);
        // expected state walk (R4)
        if (v.ini) exp_seq[en++] = 1;
        for (int s = 2; s <= 6; s++) exp_seq[en++] = s;
        if (v.rsp) begin
            exp_seq[en++] = 15; exp_seq[en++] = 7;
            if (!timed) for (int s = 9; s <= 13; s++) exp_seq[en++] = s;
        end
        exp_seq[en++] = 14; exp_seq[en++] = 0;

        @(negedge clk);
        cmd_word = w; cmd_arg = v.arg; rsp_tmo = v.tmo; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        chk(cmd_busy == 1'b1, {tag, " R5 busy after strobe"}, cmd_busy, 1);
        for (int cyc = 0; cyc < 4000; cyc++) begin
            if (cyc > 0) @(negedge clk);
            if (ce_div > 1) card_ce = (cyc % ce_div == 0);
            if (poke && cyc == 20) begin cmd_arg = ~v.arg; cmd_start = 1'b1; end
            if (poke && cyc == 21) begin cmd_arg = v.arg; cmd_start = 1'b0; end
            if (card_ce && cmd_oe && ncap < 256) begin cap = {cap[254:0], cmd_o}; ncap++; end
            if (int'(fsm_code) != last) begin
                if (gn < 32) got_seq[gn] = int'(fsm_code);
                gn++; last = int'(fsm_code);
            end
            if (fsm_code == 4'd14) n14++;
            if (fsm_code == 4'd15) n15++;
            if (prev_oe && !cmd_oe) begin fall = 1; k = 0; end
            if (fall && v.respond) begin
                k++;
                if (k >= int'(v.gap) && bi < nb) begin cmd_i = frm[nb-1-bi]; bi++; end
                else cmd_i = 1'b1;
            end
            prev_oe = cmd_oe;
            if (cmd_done) begin dones++; break; end
        end
        cmd_i = 1'b1; card_ce = 1'b1;
        chk(dones == 1, {tag, " R6 done seen"}, dones, 1);
        chk(ncap == nexp && cap == exp_tx, {tag, " R2 R3 tx frame"}, cap, exp_tx);
        seq_ok = (gn == en);
        for (int i = 0; i < en && i < 16; i++) begin
            epk = {epk[59:0], 4'(exp_seq[i])};
            if (i < gn) gpk = {gpk[59:0], 4'(got_seq[i])};
            if (i >= gn || got_seq[i] != exp_seq[i]) seq_ok = 0;
        end
        chk(seq_ok, {tag, " R4 state walk"}, gpk, epk);
        if (ce_div == 1) begin
            chk(n14 == 8, {tag, " R6 recovery length"}, n14, 8);
            chk(n15 == (v.rsp ? 2 : 0), {tag, " R7 turnaround length"}, n15, v.rsp ? 2 : 0);
        end
        chk({err_tmo, err_resp, err_crc} == {x_tmo, x_resp, x_crc},
            {tag, " R7 R10 R11 flags"}, {err_tmo, err_resp, err_crc}, {x_tmo, x_resp, x_crc});
        if (v.rsp && !timed) begin
            if (v.lng) begin exp_w = {frm[127:0]}; exp_last = 6'h3F; end
            else begin exp_w[31:0] = pay[31:0]; exp_last = v.cidx; end
        end
        chk({rsp_w3, rsp_w2, rsp_w1, rsp_w0} == exp_w, {tag, " R8 R9 response words"},
            {rsp_w3, rsp_w2, rsp_w1, rsp_w0}, exp_w);
        chk(rsp_last_idx == exp_last, {tag, " R8 last index"}, rsp_last_idx, exp_last);
        @(negedge clk);
        chk(!cmd_done && !cmd_busy, {tag, " R13 R5 done pulse and busy clear"},
            {cmd_done, cmd_busy}, 0);
        chk({err_tmo, err_resp, err_crc} == {x_tmo, x_resp, x_crc},
            {tag, " R13 flags held"}, {err_tmo, err_resp, err_crc}, {x_tmo, x_resp, x_crc});
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        vec_t sv;
        repeat (4) @(negedge clk);
        check_reset_state("reset");
        rst_n = 1'b1;
        @(negedge clk);
        // R5: strobe with start bit clear is ignored
        cmd_word = 32'h0000_0045; cmd_start = 1'b1;
        @(negedge clk); cmd_start = 1'b0;
        repeat (3) @(negedge clk);
        chk(!cmd_busy && fsm_code == 0 && !cmd_oe, "R5 strobe without start bit",
            {cmd_busy, fsm_code}, 0);

        for (int i = 0; i < NV; i++) run_cmd(VEC[i], 1, 1'b0, $sformatf("vec%0d", i));

        // R12: slow card clock, frame must be unchanged
        sv = VEC[1]; sv.idx = 6'd51; sv.arg = 32'h7654_3210;
        run_cmd(sv, 3, 1'b0, "R12 slow card clock");
        // R5: strobe while busy must not alter the command
        sv = VEC[2]; sv.arg = 32'h0000_1234;
        run_cmd(sv, 1, 1'b1, "R5 strobe while busy");

        // R1: reset in the middle of a command
        @(negedge clk);
        cmd_word = 32'h8000_0041; cmd_arg = 32'hFFFF_0000; rsp_tmo = 8'd50; cmd_start = 1'b1;
        @(negedge clk); cmd_start = 1'b0;
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_reset_state("R1 mid-command reset");
        rst_n = 1'b1;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule